// File: doc/BRIEF.md
# RAM-Open Mode Sequencer

This block moves one privileged execution link into and out of a mode where a set of designated RAMs belongs to it alone. Software asks for entry by writing a one to a request bit. The block does not grant the mode at once. It first tells every attached RAM-initialization engine to wipe its RAM. It raises the mode status only after every engine has reported completion.

Exit is also requested with a write-one bit. A sticky wipe-on-exit option decides how the exit proceeds. With the option clear, the mode drops at once. With the option set, the RAMs are wiped first, the status drops when the wipe ends, and the option then clears itself. Requests that make no sense in the current phase have no effect: entry while already open, exit while closed, or any request while a wipe is running. A busy output shows when a wipe sequence is in progress.

Top module: `ramopen_ctrl`

## Requirements
- R1: After reset the status (address 0, bit 1), the wipe option (address 1, bit 12), `busy` and every `wipe_start` line read zero.
- R2: Writing a one to the set bit (address 1, bit 8) while closed pulses all `wipe_start` lines high for exactly one cycle, starting the cycle after the write, and raises `busy`.
- R3: The status rises one cycle after the last engine's done pulse is captured. Engines may finish in any order and at different times, and the status stays low until all have finished.
- R4: Writing a one to the clear bit (address 2, bit 1) while open with the option clear drops the status on the next cycle without any wipe.
- R5: A clear while open with the option set starts a wipe on all engines. The status stays high until every engine is done and drops one cycle later.
- R6: The wipe option is write-one-to-set and reads back at address 1, bit 12. It returns to zero when an exit completes.
- R7: Writes of zero to the set, clear and option bits change nothing.
- R8: The set and clear bits always read as zero.
- R9: A set request while open, or a clear request while closed, is ignored: no wipe starts and the status is unchanged.
- R10: Set and clear requests that arrive while a wipe is in progress are ignored.
- R11: `busy` is high exactly while an entry or exit wipe is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 1 request/option register, 2 clear register |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 status, 1 request/option, 2 clear |
| rd_data | output | 32 | Read data (combinational) |
| wipe_start | output | N_ENG | One-cycle start pulse to each wipe engine |
| wipe_done | input | N_ENG | Completion pulse from each wipe engine |
| ram_open | output | 1 | Mode status |
| busy | output | 1 | A wipe sequence is in progress |

## Verification
The hardest cases depend on wipe progress: done pulses that arrive skewed across engines, and requests that land while a wipe is still waiting for some engines. The bench plays the part of the engines itself. It pulses done lines one at a time, in a scrambled order, and checks that the status does not rise early. It also holds one engine back while it writes set and clear requests, then confirms that none of them started a new wipe.

// File: rtl/ramopen_pkg.sv
package ramopen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WIPE_OPEN  = 2'd1,
        ST_OPEN       = 2'd2,
        ST_WIPE_CLOSE = 2'd3
    } ro_state_e;

    localparam int unsigned ADDR_W = 2;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FORCE  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 2'd2;

    localparam int unsigned BIT_STATUS   = 1;
    localparam int unsigned BIT_SET      = 8;
    localparam int unsigned BIT_WIPE_OPT = 12;
    localparam int unsigned BIT_CLEAR    = 1;

    typedef struct packed {
        logic set_req;
        logic clr_req;
        logic opt_set;
    } ro_cmd_t;

    function automatic logic in_wipe(ro_state_e s);
        return (s == ST_WIPE_OPEN) || (s == ST_WIPE_CLOSE);
    endfunction

endpackage

// File: rtl/ramopen_regif.sv
module ramopen_regif
    import ramopen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                status_i,
    input  logic                close_done_i,
    output ro_cmd_t             cmd_o,
    output logic                opt_o,
    output logic [DATA_W-1:0]   rd_data
);
    logic opt_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // Write-one decode; zeros in any bit position are simply not acted on.
    always_comb begin
        cmd_o.set_req = wr_en && (wr_addr == ADDR_FORCE) && wr_data[BIT_SET];
        cmd_o.opt_set = wr_en && (wr_addr == ADDR_FORCE) && wr_data[BIT_WIPE_OPT];
        cmd_o.clr_req = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[BIT_CLEAR];
    end

    // Sticky option: finishing an exit has priority over a new set.
    always_ff @(posedge clk) begin
        if (rst)               opt_q <= 1'b0;
        else if (close_done_i) opt_q <= 1'b0;
        else if (cmd_o.opt_set) opt_q <= 1'b1;
    end

    assign opt_o = opt_q;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_STATUS: rd_data[BIT_STATUS]   = status_i;
            ADDR_FORCE:  rd_data[BIT_WIPE_OPT] = opt_q;
            default:     rd_data = '0;
        endcase
    end

    // R6: the option only ever drops because an exit completed.
    a_r6_opt_clears_on_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(opt_q) |-> $past(close_done_i));

endmodule

// File: rtl/ramopen_done_track.sv
module ramopen_done_track #(
    parameter int unsigned N_ENG = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_i,
    input  logic [N_ENG-1:0] done_i,
    output logic             all_done_o
);
    logic [N_ENG-1:0] seen_q;

    // One sticky flag per engine, cleared on the edge that launches a wipe.
    for (genvar g = 0; g < N_ENG; g++) begin : g_eng
        always_ff @(posedge clk) begin
            if (rst || launch_i) seen_q[g] <= 1'b0;
            else if (done_i[g])  seen_q[g] <= 1'b1;
        end
    end

    assign all_done_o = &seen_q;

    // R3: flags start empty after a launch.
    a_r3_flags_reset_on_launch: assert property (@(posedge clk) disable iff (rst)
        launch_i |=> (seen_q == '0));

endmodule

// File: rtl/ramopen_seq.sv
module ramopen_seq
    import ramopen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ro_cmd_t   cmd_i,
    input  logic      opt_i,
    input  logic      all_done_i,
    output logic      launch_o,
    output logic      start_o,
    output logic      close_done_o,
    output logic      status_o,
    output logic      busy_o
);
    ro_state_e st_q, st_d;
    logic      start_q;

    always_comb begin
        st_d         = st_q;
        launch_o     = 1'b0;
        close_done_o = 1'b0;
        case (st_q)
            ST_IDLE: if (cmd_i.set_req) begin
                st_d     = ST_WIPE_OPEN;
                launch_o = 1'b1;
            end
            ST_WIPE_OPEN: if (all_done_i) st_d = ST_OPEN;
            ST_OPEN: if (cmd_i.clr_req) begin
                if (opt_i) begin
                    st_d     = ST_WIPE_CLOSE;
                    launch_o = 1'b1;
                end else begin
                    st_d         = ST_IDLE;
                    close_done_o = 1'b1;
                end
            end
            ST_WIPE_CLOSE: if (all_done_i) begin
                st_d         = ST_IDLE;
                close_done_o = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            start_q <= launch_o;
        end
    end

    assign start_o  = start_q;
    assign status_o = (st_q == ST_OPEN) || (st_q == ST_WIPE_CLOSE);
    assign busy_o   = in_wipe(st_q);

    // R3: the mode opens only after every engine reported.
    a_r3_open_needs_done: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_OPEN) |-> $past(all_done_i));

    // R2: a start pulse lasts a single cycle.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    // R10: no second launch while a wipe is already running.
    a_r10_no_launch_in_wipe: assert property (@(posedge clk) disable iff (rst)
        busy_o && !all_done_i |-> !launch_o);

endmodule

// File: rtl/ramopen_ctrl.sv
module ramopen_ctrl
    import ramopen_pkg::*;
#(
    parameter int unsigned N_ENG = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [1:0]         rd_addr,
    output logic [31:0]        rd_data,
    output logic [N_ENG-1:0]   wipe_start,
    input  logic [N_ENG-1:0]   wipe_done,
    output logic               ram_open,
    output logic               busy
);
    ro_cmd_t cmd;
    logic    opt, launch, start, close_done, all_done;

    ramopen_regif u_regif (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .status_i(ram_open),
        .close_done_i(close_done), .cmd_o(cmd), .opt_o(opt),
        .rd_data(rd_data)
    );

    ramopen_done_track #(.N_ENG(N_ENG)) u_track (
        .clk(clk), .rst(rst), .launch_i(launch),
        .done_i(wipe_done), .all_done_o(all_done)
    );

    ramopen_seq u_seq (
        .clk(clk), .rst(rst), .cmd_i(cmd), .opt_i(opt),
        .all_done_i(all_done), .launch_o(launch), .start_o(start),
        .close_done_o(close_done), .status_o(ram_open), .busy_o(busy)
    );

    assign wipe_start = {N_ENG{start}};

    // R11: engines are only kicked while a wipe is in progress.
    a_r11_start_implies_busy: assert property (@(posedge clk) disable iff (rst)
        (|wipe_start) |-> busy);

    // R9: a set request while open never starts a wipe.
    a_r9_set_when_open: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_FORCE && wr_data[BIT_SET] && ram_open && !busy)
        |=> !(|wipe_start) && ram_open);

endmodule

// File: tb/ramopen_ctrl_test.sv
module ramopen_ctrl_test;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [N-1:0] wipe_start;
    logic [N-1:0] wipe_done = '0;
    logic         ram_open, busy;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    ramopen_ctrl #(.N_ENG(N)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wipe_start(wipe_start), .wipe_done(wipe_done),
        .ram_open(ram_open), .busy(busy)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        wipe_done = m;
        @(negedge clk);
        wipe_done = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R1 status", d, 32'h0);
        rd(2'd1, d); check("R1 option", d, 32'h0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 start", {29'd0, wipe_start}, 32'd0);
    endtask

    task automatic t_open_skewed();
        logic [31:0] d;
        wr(2'd1, 32'h100);
        check("R2 start pulse", {29'd0, wipe_start}, 32'h7);
        check("R2 busy", {31'd0, busy}, 32'd1);
        tick();
        check("R2 pulse ends", {29'd0, wipe_start}, 32'h0);
        pulse(3'b100);
        wr(2'd1, 32'h100);
        check("R10 set during wipe", {29'd0, wipe_start}, 32'h0);
        wr(2'd2, 32'h2);
        check("R10 clear during wipe", {29'd0, wipe_start}, 32'h0);
        pulse(3'b001);
        check("R3 not open early", {31'd0, ram_open}, 32'd0);
        pulse(3'b010);
        check("R3 one cycle latency", {31'd0, ram_open}, 32'd0);
        tick();
        check("R3 open", {31'd0, ram_open}, 32'd1);
        check("R11 busy drops", {31'd0, busy}, 32'd0);
        rd(2'd0, d); check("R3 status bit1", d, 32'h2);
    endtask

    task automatic t_open_ignores();
        logic [31:0] d;
        wr(2'd1, 32'h100);
        check("R9 set while open", {29'd0, wipe_start}, 32'h0);
        check("R9 still open", {31'd0, ram_open}, 32'd1);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
        check("R7 zero writes", {31'd0, ram_open}, 32'd1);
        rd(2'd1, d); check("R7 option unchanged", d, 32'h0);
        rd(2'd2, d); check("R8 clear reads zero", d, 32'h0);
    endtask

    task automatic t_close_plain();
        wr(2'd2, 32'h2);
        check("R4 closed", {31'd0, ram_open}, 32'd0);
        check("R4 no wipe", {29'd0, wipe_start}, 32'h0);
        check("R11 not busy", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_close_wipe();
        logic [31:0] d;
        wr(2'd2, 32'h2);
        check("R9 clear while closed", {29'd0, wipe_start}, 32'h0);
        wr(2'd1, 32'h1000);
        rd(2'd1, d); check("R6 option set", d, 32'h1000);
        wr(2'd2, 32'h2);
        rd(2'd1, d); check("R9 option kept", d, 32'h1000);
        wr(2'd1, 32'h100);
        rd(2'd1, d); check("R8 set reads zero", d, 32'h1000);
        pulse(3'b111);
        tick();
        check("R3 reopen", {31'd0, ram_open}, 32'd1);
        wr(2'd2, 32'h2);
        check("R5 wipe on close", {29'd0, wipe_start}, 32'h7);
        check("R5 still open", {31'd0, ram_open}, 32'd1);
        check("R11 busy close", {31'd0, busy}, 32'd1);
        pulse(3'b011);
        wr(2'd1, 32'h100);
        check("R10 set during close", {29'd0, wipe_start}, 32'h0);
        pulse(3'b100);
        check("R5 held till next cycle", {31'd0, ram_open}, 32'd1);
        tick();
        check("R5 closed", {31'd0, ram_open}, 32'd0);
        rd(2'd1, d); check("R6 option cleared", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_open_skewed();
        t_open_ignores();
        t_close_plain();
        t_close_wipe();
        tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule